// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This combinational unit decides where a 32-bit MIPS-style core fetches next. From the current PC, the fetched instruction word and the two register operand values, it produces a redirect flag and a 32-bit next address. It also produces the register write that saves a return address for a call.

Three control-transfer instructions are recognised:
- an equality branch, with a PC-relative word offset;
- an absolute jump, which keeps the current 256 MB region;
- a jump that also links, saving the return address in register 31.

Every other instruction, and a branch whose operands differ, yields the sequential address PC+4. An active-high reset silences the unit, forcing every output to zero.

Top module: `jump_target_unit`

## Requirements
- R1: While `rst` is 1, `taken`, `target`, `link_we`, `link_reg` and `link_val` are all zero, whatever the other inputs are.
- R2: For opcode `instr[31:26]` = 6'b000100 (equality branch), `taken` is 1 exactly when `rs_val` equals `rt_val`.
- R3: A taken equality branch gives `target` = PC+4 + (sign-extended `instr[15:0]` shifted left by 2), modulo 2^32.
- R4: For opcode 6'b000010 (jump), `taken` is 1 and `target` = {(PC+4)[31:28], `instr[25:0]`, 2'b00}.
- R5: For opcode 6'b000011 (jump and link), `target` and `taken` are as in R4, `link_we` is 1, `link_reg` is 31 and `link_val` is PC+4.
- R6: When no redirect occurs, `taken` is 0 and `target` is PC+4. This covers an equality branch with unequal operands and any opcode other than the three above.
- R7: For every opcode other than 6'b000011, `link_we`, `link_reg` and `link_val` are zero.
- R8: All address sums wrap modulo 2^32. A PC of 32'hFFFF_FFFC gives a sequential address of 0, and the jump region is taken from that wrapped value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Active-high reset; forces all outputs to zero |
| pc | input | 32 | Address of the current instruction |
| instr | input | 32 | Current instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| taken | output | 1 | Redirect to `target` instead of the sequential path |
| target | output | 32 | Next fetch address |
| link_we | output | 1 | Write the return address to the register file |
| link_reg | output | 5 | Register number for the link write |
| link_val | output | 32 | Return address to write |

## Verification
The equality branch is driven with random PCs and random 16-bit offsets, with equal and then unequal operands. Offsets 16'h7FFF, 16'h8000 and 0 are added explicitly. These cases separate correct sign extension and the shift by two from zero extension or an unscaled offset.

Jumps are tried from PCs in many regions, including 32'h0FFF_FFFC. At that PC the region bits of PC+4 differ from those of PC, so it tells which of the two the splice uses.

Non-branch opcodes, the link-free jump, and a PC at the top of the address space show that link outputs stay quiet and that sums wrap.

// File: rtl/jump_target_unit.sv
module jump_target_unit #(
  parameter int unsigned LINK_REG = 31
) (
  input  logic        rst,
  input  logic [31:0] pc,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic        taken,
  output logic [31:0] target,
  output logic        link_we,
  output logic [4:0]  link_reg,
  output logic [31:0] link_val
);

  localparam logic [5:0] OP_BEQ = 6'b000100;
  localparam logic [5:0] OP_J   = 6'b000010;
  localparam logic [5:0] OP_JAL = 6'b000011;

  logic [5:0]  opcode;
  logic [31:0] seq_pc;
  logic [31:0] br_off;
  logic [31:0] br_tgt;
  logic [31:0] jmp_tgt;
  logic        is_jump;
  logic        is_call;
  logic        beq_hit;

  assign opcode  = instr[31:26];
  assign seq_pc  = pc + 32'd4;
  assign br_off  = {{14{instr[15]}}, instr[15:0], 2'b00};
  assign br_tgt  = seq_pc + br_off;
  assign jmp_tgt = {seq_pc[31:28], instr[25:0], 2'b00};

  assign is_call = (opcode == OP_JAL);
  assign is_jump = (opcode == OP_J) || is_call;
  assign beq_hit = (opcode == OP_BEQ) && (rs_val == rt_val);

  assign taken    = !rst && (beq_hit || is_jump);
  assign target   = rst     ? 32'd0   :
                    beq_hit ? br_tgt  :
                    is_jump ? jmp_tgt : seq_pc;

  assign link_we  = !rst && is_call;
  assign link_reg = link_we ? 5'(LINK_REG) : 5'd0;
  assign link_val = link_we ? seq_pc : 32'd0;

endmodule

module jump_target_unit_chk (
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        taken,
  input logic [31:0] target,
  input logic        link_we,
  input logic [4:0]  link_reg,
  input logic [31:0] link_val
);
  logic [31:0] nxt;
  assign nxt = pc + 32'd4;

  always_comb begin
    AST_RESET_QUIET: assert (!rst || (!taken && target == 32'd0 && !link_we && link_reg == 5'd0 && link_val == 32'd0)) else $error("reset outputs"); // R1
    AST_BEQ_DECIDE: assert (rst || instr[31:26] != 6'b000100 || (taken == (rs_val == rt_val))) else $error("beq decision"); // R2
    AST_SEQ_FALLBACK: assert (rst || taken || target == nxt) else $error("sequential target"); // R6
    AST_JUMP_SPLICE: assert (rst || (instr[31:26] != 6'b000010 && instr[31:26] != 6'b000011) || (taken && target[1:0] == 2'b00 && target[31:28] == nxt[31:28])) else $error("jump splice"); // R4
    AST_LINK_RETURN: assert (!link_we || (taken && link_reg == 5'd31 && link_val == nxt)) else $error("link value"); // R5
    AST_LINK_IDLE: assert (instr[31:26] == 6'b000011 || (!link_we && link_reg == 5'd0 && link_val == 32'd0)) else $error("link idle"); // R7
  end
endmodule

bind jump_target_unit jump_target_unit_chk i_chk (
  .rst(rst), .pc(pc), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
  .taken(taken), .target(target), .link_we(link_we),
  .link_reg(link_reg), .link_val(link_val)
);

// File: tb/test_jump_target_unit.sv
module test_jump_target_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pc, instr, rs_val, rt_val;
  logic        taken, link_we;
  logic [31:0] target, link_val;
  logic [4:0]  link_reg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  jump_target_unit i_jump_target_unit (
    .rst(rst), .pc(pc), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .taken(taken), .target(target), .link_we(link_we),
    .link_reg(link_reg), .link_val(link_val)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    pc = p; instr = i; rs_val = a; rt_val = b;
    #1;
  endtask

  function automatic logic [31:0] br_ref(input logic [31:0] p, input logic [15:0] off);
    logic [31:0] ext;
    ext = {{16{off[15]}}, off};
    return p + 32'd4 + (ext << 2);
  endfunction

  function automatic logic [31:0] jmp_ref(input logic [31:0] p, input logic [25:0] idx);
    logic [31:0] n;
    n = p + 32'd4;
    return {n[31:28], idx, 2'b00};
  endfunction

  task automatic check_no_link(input string req);
    chk(req, "link_we", {31'd0, link_we}, 32'd0);
    chk(req, "link_reg", {27'd0, link_reg}, 32'd0);
    chk(req, "link_val", link_val, 32'd0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    apply(32'h1234_5678, {6'b000011, 26'h3FF_FFFF}, 32'd5, 32'd5);
    chk("R1", "taken", {31'd0, taken}, 32'd0);
    chk("R1", "target", target, 32'd0);
    check_no_link("R1");
    apply(32'h0000_0040, {6'b000100, 5'd1, 5'd2, 16'h0010}, 32'd9, 32'd9);
    chk("R1", "taken beq", {31'd0, taken}, 32'd0);
    chk("R1", "target beq", target, 32'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_beq_taken;
    logic [15:0] edges [3] = '{16'h7FFF, 16'h8000, 16'h0000};
    for (int k = 0; k < 23; k++) begin
      logic [31:0] p, v;
      logic [15:0] off;
      p = $urandom() & 32'hFFFF_FFFC;
      v = $urandom();
      off = (k < 3) ? edges[k] : 16'($urandom());
      apply(p, {6'b000100, 5'd3, 5'd4, off}, v, v);
      chk("R2", "beq equal taken", {31'd0, taken}, 32'd1);
      chk("R3", "beq target", target, br_ref(p, off));
      check_no_link("R7");
    end
  endtask

  task automatic t_beq_not_taken;
    for (int k = 0; k < 15; k++) begin
      logic [31:0] p, v;
      p = $urandom() & 32'hFFFF_FFFC;
      v = $urandom();
      apply(p, {6'b000100, 5'd3, 5'd4, 16'($urandom())}, v, v ^ (32'd1 << (k % 32)));
      chk("R2", "beq unequal not taken", {31'd0, taken}, 32'd0);
      chk("R6", "beq unequal target", target, p + 32'd4);
    end
  endtask

  task automatic t_jump;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] p;
      logic [25:0] idx;
      p = {4'(k), 28'($urandom()) & 28'hFFF_FFFC};
      idx = 26'($urandom());
      apply(p, {6'b000010, idx}, $urandom(), $urandom());
      chk("R4", "j taken", {31'd0, taken}, 32'd1);
      chk("R4", "j target", target, jmp_ref(p, idx));
      check_no_link("R7");
    end
    apply(32'h0FFF_FFFC, {6'b000010, 26'h000_0010}, 32'd0, 32'd0);
    chk("R4", "j region from PC+4", target, 32'h1000_0040);
  endtask

  task automatic t_jal;
    for (int k = 0; k < 12; k++) begin
      logic [31:0] p;
      logic [25:0] idx;
      p = $urandom() & 32'hFFFF_FFFC;
      idx = 26'($urandom());
      apply(p, {6'b000011, idx}, $urandom(), $urandom());
      chk("R5", "jal taken", {31'd0, taken}, 32'd1);
      chk("R5", "jal target", target, jmp_ref(p, idx));
      chk("R5", "jal link_we", {31'd0, link_we}, 32'd1);
      chk("R5", "jal link_reg", {27'd0, link_reg}, 32'd31);
      chk("R5", "jal link_val", link_val, p + 32'd4);
    end
  endtask

  task automatic t_other_ops;
    logic [5:0] ops [6] = '{6'b000000, 6'b100011, 6'b101011, 6'b000101, 6'b001000, 6'b001111};
    for (int k = 0; k < 6; k++) begin
      logic [31:0] p, v;
      p = $urandom() & 32'hFFFF_FFFC;
      v = $urandom();
      apply(p, {ops[k], 26'($urandom())}, v, v);
      chk("R6", "other op not taken", {31'd0, taken}, 32'd0);
      chk("R6", "other op target", target, p + 32'd4);
      check_no_link("R7");
    end
  endtask

  task automatic t_wrap;
    apply(32'hFFFF_FFFC, 32'h0000_0020, 32'd1, 32'd2);
    chk("R8", "sequential wrap", target, 32'h0000_0000);
    apply(32'hFFFF_FFFC, {6'b000100, 5'd1, 5'd1, 16'hFFFF}, 32'd7, 32'd7);
    chk("R8", "beq wrap back", target, 32'hFFFF_FFFC);
    apply(32'hFFFF_FFF8, {6'b000100, 5'd1, 5'd1, 16'h0004}, 32'd7, 32'd7);
    chk("R8", "beq wrap forward", target, 32'h0000_000C);
    apply(32'hFFFF_FFFC, {6'b000011, 26'h3FF_FFFF}, 32'd0, 32'd0);
    chk("R8", "jal region wrap", target, 32'h0FFF_FFFC);
    chk("R8", "jal link wrap", link_val, 32'h0000_0000);
  endtask

  initial begin
    rst = 1'b1; pc = '0; instr = '0; rs_val = '0; rt_val = '0;
    t_reset();
    t_beq_taken();
    t_beq_not_taken();
    t_jump();
    t_jal();
    t_other_ops();
    t_wrap();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule